// File: doc/BRIEF.md
# Byte-Level Bus Master Command Sequencer

This block is the command engine of a single-bus two-wire serial master. Software writes a command word whose bits ask for a start condition, a byte transmit, a byte receive (optionally the final one of a read) and a stop condition. The engine turns the pending bits into one bus-agent operation at a time, in a fixed order. A lower-level agent produces the bit timing and reports each finished operation. Results appear as status bits, which software clears by writing ones. An enable mask turns selected status bits into a level interrupt.

The receive-done status bit doubles as flow control. While it is set, a pending receive waits in the command word, and so does any stop queued behind it. Once software clears the bit, the receive starts without a further command. Its completion raises the interrupt again. A failed read loads 0xFF into the receive buffer and leaves receive-done clear.

Top module: `i2cm_engine`

## Requirements
- R1: After reset the command word, status, enable mask and interrupt are zero, the line state reads 0 (idle) and no operation is requested.
- R2: A write to address 0 replaces the 16-bit command word. Pending bits: 0 start, 1 transmit, 3 receive, 4 receive-last, 5 stop. The write clears every status bit except bit 2 (receive-done), which keeps its value.
- R3: Writing to address 2 clears each status bit whose write-data bit is one. Only bits 14:0 are affected; bit 15 of the write data has no effect.
- R4: Pending bits are served one agent operation at a time, in the order start, transmit, receive, stop. Agent codes: 1 start, 2 send, 3 receive, 4 stop. Code and flags stay steady until the agent reports done, and each served bit is then cleared.
- R5: A transmit sends the byte last written to bits 7:0 of address 3. It sets status bit 0 on success, or status bit 1 if the agent reports an error.
- R6: During a receive the line state (address 4) reads 4. Afterwards it reads 1, both receive bits are clear, the byte appears in bits 15:8 of address 3, and status bit 2 is set.
- R7: A receive requested with the receive-last bit asks the agent to NACK the byte; a plain receive does not.
- R8: A receive that the agent reports as failed loads 0xFF into the receive buffer and leaves status bit 2 clear.
- R9: A receive is not started while status bit 2 is set. Clearing that bit starts the pending receive with no new command write, and its completion raises the interrupt again.
- R10: A stop is not issued while a receive is pending. A finished stop sets status bit 4 and returns the line state to 0.
- R11: The interrupt output rises on the cycle after a status bit is set whose enable bit (address 1, bits 14:0) is one. Disabled bits do not raise it.
- R12: Once raised, the interrupt falls only after a status clear write that leaves the whole status register zero. Partial clears and command writes leave it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 command, 1 enable, 2 status, 3 data, 4 line state) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| irq | output | 1 | Level interrupt |
| op_valid | output | 1 | Agent operation requested, held until op_done |
| op_code | output | 3 | Agent operation code |
| op_nack | output | 1 | NACK the received byte |
| op_wbyte | output | 8 | Byte to send |
| op_done | input | 1 | Agent finished the current operation (one-cycle pulse) |
| op_err | input | 1 | Agent operation failed, valid with op_done |
| op_rbyte | input | 8 | Byte received, valid with op_done |

## Verification
The hardest state to reach is a receive parked behind a still-set receive-done bit, with a stop queued after it. The bench first finishes a receive, leaves its status set, then writes a receive-last plus stop command. It idles long enough to show that no agent request appears and the interrupt stays up. It then clears only bit 2 and watches the NACKed receive and the stop go out unprompted. A behavioural model, advanced on every clock from the same port stimulus, checks the interrupt level and every agent request across the whole run.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int CMD_W  = 16;
  localparam int STS_W  = 15;
  localparam int BYTE_W = 8;

  localparam int CB_START = 0;
  localparam int CB_TX    = 1;
  localparam int CB_RX    = 3;
  localparam int CB_RXL   = 4;
  localparam int CB_STOP  = 5;

  localparam int SB_TXOK  = 0;
  localparam int SB_TXERR = 1;
  localparam int SB_RXRDY = 2;
  localparam int SB_STOP  = 4;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_START = 3'd1,
    OP_SEND  = 3'd2,
    OP_RECV  = 3'd3,
    OP_STOP  = 3'd4
  } op_e;

  typedef enum logic [3:0] {
    LS_IDLE   = 4'd0,
    LS_ACTIVE = 4'd1,
    LS_START  = 4'd2,
    LS_TXD    = 4'd3,
    LS_RXD    = 4'd4,
    LS_STOP   = 4'd5
  } line_e;
endpackage

// File: rtl/i2cm_seq.sv
module i2cm_seq
  import i2cm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CMD_W-1:0] cmd,
  input  logic             rx_held,
  input  logic             ag_done,
  output logic             op_valid,
  output op_e              op_code,
  output logic             op_nack,
  output logic             fin,
  output op_e              fin_op,
  output line_e            line_st
);
  logic  busy_q, busy_n;
  op_e   cur_q, cur_n, pick;
  logic  nack_q, nack_n;
  line_e line_q, line_n;

  function automatic line_e busy_state(op_e o);
    case (o)
      OP_START: busy_state = LS_START;
      OP_SEND:  busy_state = LS_TXD;
      OP_RECV:  busy_state = LS_RXD;
      OP_STOP:  busy_state = LS_STOP;
      default:  busy_state = LS_IDLE;
    endcase
  endfunction

  // fixed service order; a held receive also blocks the stop behind it
  always_comb begin
    pick = OP_NONE;
    if (cmd[CB_START])                pick = OP_START;
    else if (cmd[CB_TX])              pick = OP_SEND;
    else if (cmd[CB_RX] | cmd[CB_RXL]) pick = rx_held ? OP_NONE : OP_RECV;
    else if (cmd[CB_STOP])            pick = OP_STOP;
  end

  always_comb begin
    busy_n = busy_q;
    cur_n  = cur_q;
    nack_n = nack_q;
    line_n = line_q;
    if (busy_q) begin
      if (ag_done) begin
        busy_n = 1'b0;
        line_n = (cur_q == OP_STOP) ? LS_IDLE : LS_ACTIVE;
      end
    end else if (pick != OP_NONE) begin
      busy_n = 1'b1;
      cur_n  = pick;
      nack_n = (pick == OP_RECV) & cmd[CB_RXL];
      line_n = busy_state(pick);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cur_q  <= OP_NONE;
      nack_q <= 1'b0;
      line_q <= LS_IDLE;
    end else begin
      busy_q <= busy_n;
      cur_q  <= cur_n;
      nack_q <= nack_n;
      line_q <= line_n;
    end
  end

  assign op_valid = busy_q;
  assign op_code  = busy_q ? cur_q : OP_NONE;
  assign op_nack  = busy_q & nack_q;
  assign fin      = busy_q & ag_done;
  assign fin_op   = cur_q;
  assign line_st  = line_q;
endmodule

// File: rtl/i2cm_regs.sv
module i2cm_regs
  import i2cm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic              en_wr,
  input  logic              sts_wr,
  input  logic              dat_wr,
  input  logic [CMD_W-1:0]  wdata,
  input  logic              fin,
  input  op_e               fin_op,
  input  logic              ag_err,
  input  logic [BYTE_W-1:0] ag_rbyte,
  output logic [CMD_W-1:0]  cmd_q,
  output logic [STS_W-1:0]  sts_q,
  output logic [STS_W-1:0]  en_q,
  output logic [BYTE_W-1:0] rx_buf_q,
  output logic [BYTE_W-1:0] tx_byte_q,
  output logic              irq_q
);
  localparam logic [STS_W-1:0] KEEP_MASK = STS_W'(1) << SB_RXRDY;

  logic [CMD_W-1:0]  clr_mask, cmd_n;
  logic [STS_W-1:0]  set_bits, sts_base, sts_n;
  logic [BYTE_W-1:0] rx_buf_n;
  logic              rx_ld, irq_n;

  always_comb begin
    clr_mask = '0;
    set_bits = '0;
    if (fin) begin
      case (fin_op)
        OP_START: clr_mask[CB_START] = 1'b1;
        OP_SEND: begin
          clr_mask[CB_TX] = 1'b1;
          if (ag_err) set_bits[SB_TXERR] = 1'b1;
          else        set_bits[SB_TXOK]  = 1'b1;
        end
        OP_RECV: begin
          clr_mask[CB_RX]  = 1'b1;
          clr_mask[CB_RXL] = 1'b1;
          set_bits[SB_RXRDY] = ~ag_err;
        end
        OP_STOP: begin
          clr_mask[CB_STOP] = 1'b1;
          set_bits[SB_STOP] = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    cmd_n = (cmd_wr ? wdata : cmd_q) & ~clr_mask;
    if (cmd_wr)      sts_base = sts_q & KEEP_MASK;
    else if (sts_wr) sts_base = sts_q & ~wdata[STS_W-1:0];
    else             sts_base = sts_q;
    sts_n    = sts_base | set_bits;
    irq_n    = (irq_q & ~(sts_wr & (sts_n == '0))) | (|(set_bits & en_q));
    rx_ld    = fin & (fin_op == OP_RECV);
    rx_buf_n = ag_err ? {BYTE_W{1'b1}} : ag_rbyte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      sts_q     <= '0;
      en_q      <= '0;
      rx_buf_q  <= '0;
      tx_byte_q <= '0;
      irq_q     <= 1'b0;
    end else begin
      cmd_q <= cmd_n;
      sts_q <= sts_n;
      irq_q <= irq_n;
      if (en_wr)  en_q      <= wdata[STS_W-1:0];
      if (rx_ld)  rx_buf_q  <= rx_buf_n;
      if (dat_wr) tx_byte_q <= wdata[BYTE_W-1:0];
    end
  end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CMD_W-1:0]  reg_wdata,
  output logic [CMD_W-1:0]  reg_rdata,
  output logic              irq,
  output logic              op_valid,
  output logic [2:0]        op_code,
  output logic              op_nack,
  output logic [BYTE_W-1:0] op_wbyte,
  input  logic              op_done,
  input  logic              op_err,
  input  logic [BYTE_W-1:0] op_rbyte
);
  logic [CMD_W-1:0]  cmd_q;
  logic [STS_W-1:0]  sts_q, en_q;
  logic [BYTE_W-1:0] rx_buf_q, tx_byte_q;
  logic              fin, irq_q;
  op_e               fin_op, op_sel;
  line_e             line_st;

  i2cm_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr(reg_wr && reg_addr == ADDR_W'(0)),
    .en_wr (reg_wr && reg_addr == ADDR_W'(1)),
    .sts_wr(reg_wr && reg_addr == ADDR_W'(2)),
    .dat_wr(reg_wr && reg_addr == ADDR_W'(3)),
    .wdata(reg_wdata), .fin(fin), .fin_op(fin_op),
    .ag_err(op_err), .ag_rbyte(op_rbyte),
    .cmd_q(cmd_q), .sts_q(sts_q), .en_q(en_q),
    .rx_buf_q(rx_buf_q), .tx_byte_q(tx_byte_q), .irq_q(irq_q)
  );

  i2cm_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cmd(cmd_q),
    .rx_held(sts_q[SB_RXRDY]), .ag_done(op_done),
    .op_valid(op_valid), .op_code(op_sel), .op_nack(op_nack),
    .fin(fin), .fin_op(fin_op), .line_st(line_st)
  );

  always_comb begin
    case (reg_addr)
      ADDR_W'(0): reg_rdata = cmd_q;
      ADDR_W'(1): reg_rdata = {1'b0, en_q};
      ADDR_W'(2): reg_rdata = {1'b0, sts_q};
      ADDR_W'(3): reg_rdata = {rx_buf_q, tx_byte_q};
      ADDR_W'(4): reg_rdata = CMD_W'(line_st);
      default:    reg_rdata = '0;
    endcase
  end

  assign op_code  = op_sel;
  assign op_wbyte = tx_byte_q;
  assign irq      = irq_q;
endmodule

// File: rtl/i2cm_engine_chk.sv
module i2cm_engine_chk
  import i2cm_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [2:0]       reg_addr,
  input logic             irq,
  input logic             op_valid,
  input logic [2:0]       op_code,
  input logic             op_nack,
  input logic             op_done,
  input logic [CMD_W-1:0] cmd_q,
  input logic [STS_W-1:0] sts_q,
  input logic [3:0]       line_st
);
  assert_rx_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(op_valid) && op_code == 3'd3) |-> !sts_q[SB_RXRDY]);

  assert_op_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_done) |=> (op_valid && $stable(op_code) && $stable(op_nack)));

  assert_stop_after_rx_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(op_valid) && op_code == 3'd4) |-> !(cmd_q[CB_RX] || cmd_q[CB_RXL]));

  assert_nack_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(op_valid) && op_code == 3'd3) |-> (op_nack == cmd_q[CB_RXL]));

  assert_rx_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd3) |-> (line_st == 4'd4));

  assert_irq_fall_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> ($past(reg_wr && reg_addr == 3'd2) && sts_q == '0));

  assert_irq_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (sts_q != '0));
endmodule

bind i2cm_engine i2cm_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .irq(irq), .op_valid(op_valid), .op_code(op_code), .op_nack(op_nack),
  .op_done(op_done), .cmd_q(cmd_q), .sts_q(sts_q), .line_st(line_st)
);

// File: tb/i2cm_engine_tb.sv
module i2cm_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq, op_valid, op_nack;
  logic [2:0]  op_code;
  logic [7:0]  op_wbyte;
  logic        op_done = 1'b0;
  logic        op_err = 1'b0;
  logic [7:0]  op_rbyte = '0;

  int tests = 0, fails = 0;
  bit ag_fail = 0;
  int cnt = 0;
  bit prev_v = 0;
  int rxq[$];
  int oplog[$];   // code*2 + nack at each new request
  int sentb[$];

  // reference model state
  bit m_busy, m_irq, m_nack;
  int m_op, m_cmd, m_sts, m_en, m_state;

  i2cm_engine u_dut (.*);

  always #10 clk = ~clk;

  // bus agent: answers each request three cycles after it appears
  always @(negedge clk) begin
    if (rst_n) begin
      if (op_valid && !prev_v) begin
        oplog.push_back(op_code * 2 + op_nack);
        if (op_code == 3'd2) sentb.push_back(op_wbyte);
      end
      prev_v = op_valid;
      if (op_done) op_done = 1'b0;
      else if (op_valid) begin
        cnt++;
        if (cnt == 3) begin
          cnt = 0;
          op_done = 1'b1;
          op_err = ag_fail;
          if (op_code == 3'd3 && !ag_fail && rxq.size() > 0) op_rbyte = 8'(rxq.pop_front());
          else op_rbyte = 8'h00;
        end
      end
    end
  end

  // behavioural model, advanced from the port stimulus each clock
  always @(posedge clk or negedge rst_n) begin
    int setb, ncmd, base, nsts, pk;
    if (!rst_n) begin
      m_busy = 0; m_irq = 0; m_nack = 0; m_op = 0;
      m_cmd = 0; m_sts = 0; m_en = 0; m_state = 0;
    end else begin
      setb = 0;
      ncmd = (reg_wr && reg_addr == 0) ? int'(reg_wdata) : m_cmd;
      if (reg_wr && reg_addr == 0)      base = m_sts & 4;
      else if (reg_wr && reg_addr == 2) base = m_sts & ~(reg_wdata & 16'h7FFF);
      else                              base = m_sts;
      if (m_busy) begin
        if (op_done) begin
          m_busy = 0;
          m_state = 1;
          case (m_op)
            1: ncmd &= ~1;
            2: begin ncmd &= ~2; setb = op_err ? 2 : 1; end
            3: begin ncmd &= ~'h18; if (!op_err) setb = 4; end
            4: begin ncmd &= ~'h20; setb = 'h10; m_state = 0; end
            default: ;
          endcase
        end
      end else begin
        pk = 0;
        if (m_cmd & 1)         pk = 1;
        else if (m_cmd & 2)    pk = 2;
        else if (m_cmd & 'h18) pk = (m_sts & 4) ? 0 : 3;
        else if (m_cmd & 'h20) pk = 4;
        if (pk != 0) begin
          m_busy = 1; m_op = pk;
          m_nack = (pk == 3) && ((m_cmd & 'h10) != 0);
          m_state = pk + 1;
        end
      end
      nsts = base | setb;
      m_irq = (m_irq && !(reg_wr && reg_addr == 2 && nsts == 0)) || ((setb & m_en) != 0);
      if (reg_wr && reg_addr == 1) m_en = reg_wdata & 16'h7FFF;
      m_cmd = ncmd;
      m_sts = nsts;
    end
  end

  // cycle compare of interrupt and agent requests (R4 R7 R11 R12)
  always @(negedge clk) begin
    if (rst_n) begin
      tests++;
      if (irq !== m_irq || op_valid !== m_busy ||
          (m_busy && (op_code !== 3'(m_op) || op_nack !== m_nack))) begin
        fails++;
        $display("FAIL R4/R11/R12 cycle: irq=%0b v=%0b code=%0d nack=%0b exp irq=%0b v=%0b code=%0d nack=%0b",
                 irq, op_valid, op_code, op_nack, m_irq, m_busy, m_op, m_nack);
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_addr = 3'(a); reg_wdata = 16'(d); reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input int a, input int mask, input int exp, input string tag);
    int got;
    reg_addr = 3'(a);
    #1;
    got = int'(reg_rdata) & mask;
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: addr %0d got 0x%0h exp 0x%0h", tag, a, got, exp);
    end
  endtask

  task automatic chk(input bit ok, input int got, input int exp, input string tag);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got 0x%0h exp 0x%0h", tag, got, exp);
    end
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_chk(0, 'hFFFF, 0, "R1 cmd");
    rd_chk(2, 'hFFFF, 0, "R1 status");
    rd_chk(4, 'hFFFF, 0, "R1 line state");
    chk(irq === 1'b0 && op_valid === 1'b0, irq, 0, "R1 irq/request");

    wr(1, 'h7FFF);
    wr(3, 'hA5);
    wr(0, 'h0003);           // start + transmit
    settle();
    rd_chk(2, 'hFFFF, 'h0001, "R5 tx ok status");
    rd_chk(0, 'hFFFF, 0, "R4 bits cleared");
    rd_chk(4, 'hFFFF, 1, "R4 active state");
    chk(oplog.size() == 2 && oplog[0] == 2 && oplog[1] == 4, oplog.size(), 2, "R4 start then send order");
    chk(sentb.size() == 1 && sentb[0] == 'hA5, sentb.size(), 'hA5, "R5 sent byte");
    chk(irq === 1'b1, irq, 1, "R11 irq on enabled status");
    wr(2, 'h0001);
    rd_chk(2, 'hFFFF, 0, "R3 w1c");
    chk(irq === 1'b0, irq, 0, "R12 irq low after full clear");

    ag_fail = 1;
    wr(0, 'h0002);
    settle();
    ag_fail = 0;
    rd_chk(2, 'hFFFF, 'h0002, "R5 tx error status");
    wr(2, 'hFFFF);
    rd_chk(2, 'hFFFF, 0, "R3 clear all");

    wr(0, 'h0022);           // transmit + stop
    settle();
    rd_chk(2, 'hFFFF, 'h0011, "R10 stop status");
    rd_chk(4, 'hFFFF, 0, "R10 idle after stop");
    wr(2, 'h8000);
    rd_chk(2, 'hFFFF, 'h0011, "R3 bit15 ignored");
    wr(2, 'h0001);
    rd_chk(2, 'hFFFF, 'h0010, "R3 partial clear");
    chk(irq === 1'b1, irq, 1, "R12 irq held on partial clear");
    wr(2, 'h0010);
    chk(irq === 1'b0, irq, 0, "R12 irq low when zero");

    rxq.push_back('h3C);
    wr(0, 'h0009);           // start + receive
    while (!(op_valid && op_code == 3'd3)) @(negedge clk);
    rd_chk(4, 'hFFFF, 4, "R6 receive state");
    settle();
    rd_chk(3, 'hFF00, 'h3C00, "R6 buffer");
    rd_chk(2, 'hFFFF, 'h0004, "R6 rx done");
    rd_chk(0, 'hFFFF, 0, "R6 rx bits cleared");
    rd_chk(4, 'hFFFF, 1, "R6 back to active");

    // receive-last + stop while rx done still set
    n0 = oplog.size();
    wr(0, 'h0030);
    settle();
    chk(oplog.size() == n0, oplog.size(), n0, "R9 receive stalled");
    rd_chk(0, 'hFFFF, 'h0030, "R2 command kept pending");
    rd_chk(2, 'hFFFF, 'h0004, "R2 rx done survives command write");
    chk(irq === 1'b1, irq, 1, "R12 irq kept over command write");
    rxq.push_back('h5A);
    wr(2, 'h0004);
    settle();
    chk(oplog.size() == n0 + 2 && oplog[n0] == 7, oplog.size(), n0 + 2, "R7 nack on last receive");
    chk(oplog.size() == n0 + 2 && oplog[n0 + 1] == 8, oplog.size(), n0 + 2, "R10 stop after receive");
    rd_chk(3, 'hFF00, 'h5A00, "R9 resumed byte");
    rd_chk(2, 'hFFFF, 'h0014, "R9 status after resume");
    chk(irq === 1'b1, irq, 1, "R9 irq raised again");

    wr(2, 'h7FFF);
    ag_fail = 1;
    wr(0, 'h0008);
    settle();
    ag_fail = 0;
    rd_chk(3, 'hFF00, 'hFF00, "R8 failed read buffer");
    rd_chk(2, 'hFFFF, 0, "R8 rx done not set");
    rd_chk(4, 'hFFFF, 1, "R8 state active");

    n0 = oplog.size();
    wr(0, 'hFFC0);
    settle();
    chk(oplog.size() == n0, oplog.size(), n0, "R2 non-command bits start nothing");
    rd_chk(0, 'hFFFF, 'hFFC0, "R2 full 16-bit write");
    wr(0, 0);

    wr(1, 0);
    wr(0, 'h0002);
    settle();
    rd_chk(2, 'hFFFF, 'h0001, "R11 status set while masked");
    chk(irq === 1'b0, irq, 0, "R11 masked bit keeps irq low");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule